// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage, in-order, 32-bit pipeline. For each of the two ALU operands it decides whether the value read from the register file is still current, or whether a younger result that has not yet been written back must be used instead. Two results can be used in place of the register-file value. One is the ALU result held one stage ahead in the memory stage. The other is the value about to be written back, held two stages ahead.

The block compares the two source register indices of the instruction in execute with the destination index and write-enable of each of the two older instructions. From this it produces a 2-bit select code per operand and drives a three-way operand multiplexer with it. The design is purely combinational, so both the selects and the operands are valid in the same cycle as the inputs.

The block compares whatever destination index the pipeline carries, whether that index came from the ALU destination field or from the load target field. The choice between an immediate and a register operand is made by a later multiplexer and is not part of this block.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying match, a select is 2'b00 and its operand equals the register-file value for that operand.
- R2: When the memory-stage write-enable is 1, its destination is nonzero and the destination equals source A, sel_a is 2'b10 and opnd_a equals the memory-stage result.
- R3: The R2 test applied against source B gives sel_b 2'b10 and opnd_b equal to the memory-stage result.
- R4: When the write-back-stage write-enable is 1, its destination is nonzero and the destination equals an operand's source, and R2/R3 do not apply to that operand, the select is 2'b01 and the operand equals the write-back value.
- R5: When both stages qualify for the same source, the memory-stage result wins (select 2'b10).
- R6: A destination index of 0 never causes a bypass, whatever the write-enables.
- R7: A stage whose write-enable is 0 never causes a bypass, even when its destination matches. The other stage may still bypass.
- R8: The two operands are decided independently. Identical sources may both bypass from the same stage.
- R9: Outputs follow the inputs in the same cycle, with no clock or stored state. A change of the selected data input appears on the operand at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Source register index for operand A |
| src_b_idx | input | 5 | Source register index for operand B |
| exm_dst | input | 5 | Destination index held in the memory-stage register |
| exm_wen | input | 1 | Register-write flag of the memory-stage instruction |
| wbk_dst | input | 5 | Destination index held in the write-back-stage register |
| wbk_wen | input | 1 | Register-write flag of the write-back-stage instruction |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| exm_val | input | 32 | ALU result held in the memory stage |
| wbk_val | input | 32 | Value being written back |
| sel_a | output | 2 | Bypass select for operand A |
| sel_b | output | 2 | Bypass select for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because no register lies between any input and any output. The bench changes inputs only on the falling clock edge and samples all four outputs 5 ns later, inside the same cycle and before the next change. Each check therefore sees the settled response to exactly one input pattern. The R9 check changes only a data input between two samples and expects the operand to follow it without waiting for an edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // Select codes; the encoding is decoded by the operand multiplexer
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WBK = 2'b01,
      SEL_EXM = 2'b10
   } fwd_sel_e;

   localparam int SEL_W = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int AW        = 5,
   parameter bit ZERO_EXCL = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          wen,
   output logic          hit
);
   localparam logic [AW-1:0] ZERO_IDX = '0;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("fwd_match: AW must be at least 1");
      end
      if (ZERO_EXCL) begin : g_zero_excl
         // index zero is a constant register and never carries a result
         always_comb hit = wen && (dst != ZERO_IDX) && (dst == src);
      end else begin : g_plain
         always_comb hit = wen && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick (
   input  logic       hit_exm,
   input  logic       hit_wbk,
   output logic [1:0] sel
);
   import fwd_pkg::*;

   always_comb begin
      // the younger result has precedence
      if (hit_exm)      sel = SEL_EXM;
      else if (hit_wbk) sel = SEL_WBK;
      else              sel = SEL_RF;
   end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux #(
   parameter int DW = 32
) (
   input  logic [1:0]    sel,
   input  logic [DW-1:0] rf,
   input  logic [DW-1:0] exm,
   input  logic [DW-1:0] wbk,
   output logic [DW-1:0] out
);
   import fwd_pkg::*;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("fwd_mux: DW must be at least 1");
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_EXM: out = exm;
         SEL_WBK: out = wbk;
         default: out = rf;
      endcase
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
   parameter int AW        = 5,
   parameter int DW        = 32,
   parameter bit ZERO_EXCL = 1'b1
) (
   input  logic [AW-1:0] src_a_idx,
   input  logic [AW-1:0] src_b_idx,
   input  logic [AW-1:0] exm_dst,
   input  logic          exm_wen,
   input  logic [AW-1:0] wbk_dst,
   input  logic          wbk_wen,
   input  logic [DW-1:0] rf_a,
   input  logic [DW-1:0] rf_b,
   input  logic [DW-1:0] exm_val,
   input  logic [DW-1:0] wbk_val,
   output logic [1:0]    sel_a,
   output logic [1:0]    sel_b,
   output logic [DW-1:0] opnd_a,
   output logic [DW-1:0] opnd_b
);
   localparam int NOPND = 2;

   logic [AW-1:0] src_v [NOPND];
   logic [DW-1:0] rf_v  [NOPND];
   logic [DW-1:0] out_v [NOPND];
   logic [1:0]    sel_v [NOPND];
   logic          h_exm [NOPND];
   logic          h_wbk [NOPND];

   assign src_v[0] = src_a_idx;
   assign src_v[1] = src_b_idx;
   assign rf_v[0]  = rf_a;
   assign rf_v[1]  = rf_b;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("fwd_unit: AW out of range");
      end
      for (genvar g = 0; g < NOPND; g++) begin : g_opnd
         fwd_match #(.AW(AW), .ZERO_EXCL(ZERO_EXCL)) u_m_exm (
            .src(src_v[g]), .dst(exm_dst), .wen(exm_wen), .hit(h_exm[g]));
         fwd_match #(.AW(AW), .ZERO_EXCL(ZERO_EXCL)) u_m_wbk (
            .src(src_v[g]), .dst(wbk_dst), .wen(wbk_wen), .hit(h_wbk[g]));
         fwd_pick u_pick (
            .hit_exm(h_exm[g]), .hit_wbk(h_wbk[g]), .sel(sel_v[g]));
         fwd_mux #(.DW(DW)) u_mux (
            .sel(sel_v[g]), .rf(rf_v[g]), .exm(exm_val), .wbk(wbk_val),
            .out(out_v[g]));
      end
   endgenerate

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = out_v[0];
   assign opnd_b = out_v[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int AW        = 5,
   parameter int DW        = 32,
   parameter bit ZERO_EXCL = 1'b1
) (
   input logic [AW-1:0] src_a_idx,
   input logic [AW-1:0] src_b_idx,
   input logic [AW-1:0] exm_dst,
   input logic          exm_wen,
   input logic [AW-1:0] wbk_dst,
   input logic          wbk_wen,
   input logic [DW-1:0] rf_a,
   input logic [DW-1:0] rf_b,
   input logic [DW-1:0] exm_val,
   input logic [DW-1:0] wbk_val,
   input logic [1:0]    sel_a,
   input logic [1:0]    sel_b,
   input logic [DW-1:0] opnd_a,
   input logic [DW-1:0] opnd_b
);
   logic known;
   assign known = !$isunknown({src_a_idx, src_b_idx, exm_dst, exm_wen,
                               wbk_dst, wbk_wen, sel_a, sel_b});

   always_comb begin
      if (known) begin
         // R2: a memory-stage select on A needs a live, matching destination
         a_r2_exm_a_valid: assert (sel_a != 2'b10 ||
            (exm_wen && exm_dst == src_a_idx && (!ZERO_EXCL || exm_dst != '0)))
            else $error("sel_a picks memory stage without a match");
         // R3: same on B
         a_r3_exm_b_valid: assert (sel_b != 2'b10 ||
            (exm_wen && exm_dst == src_b_idx && (!ZERO_EXCL || exm_dst != '0)))
            else $error("sel_b picks memory stage without a match");
         // R4: a write-back select needs a live, matching destination
         a_r4_wbk_valid: assert ((sel_a != 2'b01 || (wbk_wen && wbk_dst == src_a_idx)) &&
                                 (sel_b != 2'b01 || (wbk_wen && wbk_dst == src_b_idx)))
            else $error("write-back select without a match");
         // R7: a disabled stage is never chosen
         a_r7_wen_gate: assert ((exm_wen || (sel_a != 2'b10 && sel_b != 2'b10)) &&
                                (wbk_wen || (sel_a != 2'b01 && sel_b != 2'b01)))
            else $error("bypass from a stage that writes no register");
         // R1: the select code 2'b11 is never produced
         a_r1_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("illegal select code");
      end
   end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW), .ZERO_EXCL(ZERO_EXCL)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [4:0]  src_a_idx, src_b_idx, exm_dst, wbk_dst;
   logic        exm_wen, wbk_wen;
   logic [31:0] rf_a, rf_b, exm_val, wbk_val;
   logic [1:0]  sel_a, sel_b;
   logic [31:0] opnd_a, opnd_b;

   fwd_unit u0 (.*);

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] D_RFA = 32'hA0A0_0001;
   localparam logic [31:0] D_RFB = 32'hB0B0_0002;
   localparam logic [31:0] D_EXM = 32'hE0E0_0003;
   localparam logic [31:0] D_WBK = 32'hC0C0_0004;

   typedef struct packed {
      logic [3:0] req;
      logic [4:0] sa, sb, ed;
      logic       ew;
      logic [4:0] wd;
      logic       ww;
      logic [1:0] xa, xb;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1
      '{4'd2, 5'd5,  5'd6,  5'd5,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // R2
      '{4'd3, 5'd5,  5'd6,  5'd6,  1'b1, 5'd0,  1'b0, 2'b00, 2'b10}, // R3
      '{4'd4, 5'd7,  5'd8,  5'd0,  1'b0, 5'd7,  1'b1, 2'b01, 2'b00}, // R4
      '{4'd4, 5'd7,  5'd8,  5'd0,  1'b0, 5'd8,  1'b1, 2'b00, 2'b01}, // R4
      '{4'd5, 5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 2'b10, 2'b10}, // R5
      '{4'd8, 5'd9,  5'd3,  5'd3,  1'b1, 5'd9,  1'b1, 2'b01, 2'b10}, // R8
      '{4'd6, 5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R6
      '{4'd7, 5'd12, 5'd13, 5'd12, 1'b0, 5'd13, 1'b0, 2'b00, 2'b00}, // R7
      '{4'd7, 5'd12, 5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 2'b01, 2'b01}, // R7
      '{4'd6, 5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'b10, 2'b10}, // R6
      '{4'd8, 5'd4,  5'd0,  5'd0,  1'b1, 5'd4,  1'b1, 2'b01, 2'b00}  // R8
   };

   function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
      return (s == 2'b10) ? exm_val : (s == 2'b01) ? wbk_val : rf;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      src_a_idx = v.sa; src_b_idx = v.sb;
      exm_dst = v.ed;   exm_wen = v.ew;
      wbk_dst = v.wd;   wbk_wen = v.ww;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      src_a_idx = '0; src_b_idx = '0; exm_dst = '0; wbk_dst = '0;
      exm_wen = 1'b0; wbk_wen = 1'b0;
      rf_a = D_RFA; rf_b = D_RFB; exm_val = D_EXM; wbk_val = D_WBK;

      // idle state: nothing writes, both operands from the register file (R1)
      @(negedge clk); #5;
      chk("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
      chk("R1 idle sel_b", {30'd0, sel_b}, 32'd0);
      chk("R1 idle opnd_a", opnd_a, D_RFA);
      chk("R1 idle opnd_b", opnd_b, D_RFB);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         #5;
         chk($sformatf("R%0d vec%0d sel_a", VECS[i].req, i), {30'd0, sel_a}, {30'd0, VECS[i].xa});
         chk($sformatf("R%0d vec%0d sel_b", VECS[i].req, i), {30'd0, sel_b}, {30'd0, VECS[i].xb});
         chk($sformatf("R%0d vec%0d opnd_a", VECS[i].req, i), opnd_a, pick(VECS[i].xa, D_RFA));
         chk($sformatf("R%0d vec%0d opnd_b", VECS[i].req, i), opnd_b, pick(VECS[i].xb, D_RFB));
      end

      // R9: data change on the selected input shows up within the cycle
      @(negedge clk);
      drive(VECS[5]);            // both operands select the memory stage
      #2;
      exm_val = 32'h1234_5678;
      #3;
      chk("R9 opnd_a follows", opnd_a, 32'h1234_5678);
      chk("R9 opnd_b follows", opnd_b, 32'h1234_5678);
      // R9: unselected input changes have no effect
      wbk_val = 32'hDEAD_0000; rf_a = 32'h0; #1;
      chk("R9 opnd_a ignores others", opnd_a, 32'h1234_5678);
      exm_val = D_EXM; wbk_val = D_WBK; rf_a = D_RFA;

      // R6: register 0 on both stages with sources 0 and write-enables set
      @(negedge clk);
      src_a_idx = 5'd0; src_b_idx = 5'd0;
      exm_dst = 5'd0; exm_wen = 1'b1; wbk_dst = 5'd0; wbk_wen = 1'b1;
      rf_a = 32'h0000_00AA; #5;
      chk("R6 zero opnd_a", opnd_a, 32'h0000_00AA);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule